// File: doc/BRIEF.md
# Reed-Solomon Error Locator Search and Corrector

This block is the last stage of a Reed-Solomon decoder over GF(2^8) for a shortened code of 219 symbols that corrects up to 9 symbol errors. An upstream stage supplies the error-locator polynomial and the error-evaluator polynomial. This block steps through every codeword position and evaluates the locator polynomial at each one. At each root it finds, it computes the error value by the quotient formula.

The search runs from the lowest-degree position to the highest. As a result, the error values are produced in the reverse of the order in which the symbols were received. A stack stores one value per position, with zero at positions that are not roots, and pops them back in received order. Each popped value is XORed with the matching symbol from an internal copy of the received word.

The received symbols stream in after the start strobe, while the search runs. The corrected word leaves as a stream of 219 symbols, together with the number of roots found and a flag that marks the word as uncorrectable. A bypass input tells the block that the syndromes were all zero. In that case the word is passed through unchanged.

Top module: `rs_chien_corrector`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `err_count` and `uncorrectable` are all 0.
- R2: Each accepted start produces exactly N = 219 consecutive `out_valid` cycles. The symbols leave in the same order as they were received: the first symbol received is the highest-degree coefficient, degree N-1, and the stream ends at degree 0.
- R3: A position of degree p, for p in 0..N-1, is an error position exactly when the locator evaluates to zero at alpha^(-p). Alpha is 0x02 in GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1. Locator coefficient i sits at bits [8i+7:8i] of `lambda_coef`, for i = 0..9.
- R4: At an error position the output symbol is the received symbol XOR Omega(x)/Lambda'(x), taken at x = alpha^(-p). Lambda' keeps only the odd-degree terms, so Lambda'(x) is the sum of lambda_i·x^(i-1) over odd i. Omega coefficient i sits at bits [8i+7:8i] of `omega_coef`, for i = 0..8.
- R5: A symbol at a position that is not a root leaves unchanged.
- R6: `err_count` equals the number of roots found among degrees 0..N-1. It is valid from the first symbol of the stream and holds steady for the whole stream.
- R7: `uncorrectable` is 1 when the number of roots found differs from the degree of the locator, which is the highest index with a nonzero coefficient. In that case every output symbol equals the received symbol.
- R8: When `bypass` is 1 at start, every output symbol equals the received symbol, and `err_count` and `uncorrectable` are 0.
- R9: A start pulse that arrives while a word is in progress is ignored: the current stream continues unchanged and no extra stream follows.
- R10: Received symbols are accepted only on `rx_valid` cycles after start. Gaps are allowed, and output begins only after all N symbols have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a word; sampled only when idle |
| bypass | input | 1 | The syndromes were all zero; pass the word through |
| lambda_coef | input | 80 | Error-locator coefficients 0..9, 8 bits each |
| omega_coef | input | 72 | Error-evaluator coefficients 0..8, 8 bits each |
| rx_valid | input | 1 | `rx_sym` carries a received symbol |
| rx_sym | input | 8 | Received symbol, highest degree first |
| out_valid | output | 1 | `out_sym` carries a corrected symbol |
| out_sym | output | 8 | Corrected symbol |
| err_count | output | 8 | Roots found in the last word |
| uncorrectable | output | 1 | Root count does not match the locator degree |

## Verification
The search occupies the N cycles that follow the start edge. The emit phase begins on the edge after the search has finished and the last received symbol has been accepted. The first `out_valid` appears one register later, so with a gap-free received stream, output starts N+2 cycles after start. `err_count` and `uncorrectable` are registered on the edge that enters the emit phase, so they are already valid when the first symbol appears.

The scoreboard therefore does not count cycles. It compares each `out_valid` symbol in arrival order with the value predicted when the word was launched. It checks the status at the first symbol of each word, and it counts any symbol that appears with no word pending as a failure.

// File: rtl/rscf_pkg.sv
// Package rscf_pkg
// GF(2^8) arithmetic shared by the search unit and the top level.
// Assumes the field polynomial x^8+x^4+x^3+x^2+1 and alpha = 0x02.
package rscf_pkg;

    localparam int          SYM_W    = 8;
    localparam logic [7:0]  FIELD_LO = 8'h1D;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HOLD,
        ST_EMIT
    } rscf_state_e;

    // Multiply two field elements by shift and conditional reduction.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? FIELD_LO : 8'h00);
        end
        return acc;
    endfunction

    // Raise alpha to a non-negative power.
    function automatic logic [7:0] gf_alpha_pow(input int e);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < (e % 255); i++) r = gf_mul(r, 8'h02);
        return r;
    endfunction

    // Invert a field element as x^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] r;
        sq = x;
        r  = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

endpackage

// File: rtl/rscf_search.sv
// Module rscf_search
// Root search and error-value unit. On load it captures the locator
// and evaluator coefficients. Each step multiplies term i by
// alpha^(-i), so in step p the terms sum to the polynomial value at
// alpha^(-p). The error value is Omega * x / (odd-term sum), which
// equals Omega(x) / Lambda'(x).
// Assumes that load and step never coincide.
module rscf_search
    import rscf_pkg::*;
#(
    parameter int T = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [(T+1)*8-1:0]   lambda_flat,
    input  logic [T*8-1:0]       omega_flat,
    output logic                 is_root,
    output logic [7:0]           err_val
);

    logic [7:0] lam_t [0:T];
    logic [7:0] om_t  [0:T-1];
    logic [7:0] xinv;
    logic [7:0] lam_sum;
    logic [7:0] odd_sum;
    logic [7:0] om_sum;

    // Term registers: capture on load, scale by alpha^(-i) on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= T; i++) lam_t[i] <= '0;
            for (int i = 0; i < T; i++)  om_t[i]  <= '0;
            xinv <= 8'h01;
        end else if (load) begin
            for (int i = 0; i <= T; i++) lam_t[i] <= lambda_flat[i*8 +: 8];
            for (int i = 0; i < T; i++)  om_t[i]  <= omega_flat[i*8 +: 8];
            xinv <= 8'h01;
        end else if (step) begin
            for (int i = 0; i <= T; i++) lam_t[i] <= gf_mul(lam_t[i], gf_alpha_pow((255 - i) % 255));
            for (int i = 0; i < T; i++)  om_t[i]  <= gf_mul(om_t[i], gf_alpha_pow((255 - i) % 255));
            xinv <= gf_mul(xinv, gf_alpha_pow(254));
        end
    end

    // Sum the terms into the locator value, its odd part and the evaluator value.
    always_comb begin
        lam_sum = '0;
        odd_sum = '0;
        om_sum  = '0;
        for (int i = 0; i <= T; i++) begin
            lam_sum = lam_sum ^ lam_t[i];
            if ((i % 2) == 1) odd_sum = odd_sum ^ lam_t[i];
        end
        for (int i = 0; i < T; i++) om_sum = om_sum ^ om_t[i];
    end

    // Flag a root and form its error value; non-roots yield zero.
    always_comb begin
        is_root = (lam_sum == 8'h00);
        err_val = is_root ? gf_mul(gf_mul(om_sum, xinv), gf_inv(odd_sum)) : 8'h00;
    end

endmodule

// File: rtl/rscf_lifo.sv
// Module rscf_lifo
// Stack of DEPTH symbols. A push writes at the current level. The top
// entry, at level-1, is shown combinationally on dout.
// Assumes that the caller never pushes when full and never pops when empty.
module rscf_lifo #(
    parameter int DEPTH = 219,
    parameter int W     = 8,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level
);

    logic [W-1:0]      mem [0:DEPTH-1];
    logic [ADDR_W-1:0] top_ptr;

    // Storage write at the current level.
    always_ff @(posedge clk) begin
        if (push) mem[ADDR_W'(level)] <= din;
    end

    // Level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)    level <= '0;
        else if (push) level <= level + LVL_W'(1);
        else if (pop)  level <= level - LVL_W'(1);
    end

    // Top-of-stack read.
    always_comb begin
        top_ptr = ADDR_W'(level - LVL_W'(1));
        dout    = mem[top_ptr];
    end

endmodule

// File: rtl/rscf_rxbuf.sv
// Module rscf_rxbuf
// Holds the received word in arrival order. The fill count restarts on
// clear, and reads are indexed by stream position.
// Assumes that wr_en is only raised while the count is below DEPTH.
module rscf_rxbuf #(
    parameter int DEPTH = 219,
    parameter int W     = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [W-1:0]      rd_data,
    output logic [CNT_W-1:0]  count
);

    logic [W-1:0] mem [0:DEPTH-1];

    // Symbol storage.
    always_ff @(posedge clk) begin
        if (wr_en) mem[ADDR_W'(count)] <= wr_data;
    end

    // Fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (wr_en)      count <= count + CNT_W'(1);
    end

    // Indexed read.
    always_comb rd_data = mem[rd_idx];

endmodule

// File: rtl/rs_chien_corrector.sv
// Module rs_chien_corrector
// Locates errors over a shortened word of N symbols and corrects them.
// SCAN: N search steps that push error values into a stack, lowest
//       degree first; received symbols are collected at the same time.
// HOLD: wait until all N received symbols are present.
// EMIT: pop the stack in received order and XOR with the stored word.
// Assumes Lambda(0) is nonzero and N <= 255.
module rs_chien_corrector
    import rscf_pkg::*;
#(
    parameter int N = 219,
    parameter int T = 9,
    localparam int CNT_W = $clog2(N + 1),
    localparam int IDX_W = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 bypass,
    input  logic [(T+1)*8-1:0]   lambda_coef,
    input  logic [T*8-1:0]       omega_coef,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_sym,
    output logic                 out_valid,
    output logic [7:0]           out_sym,
    output logic [CNT_W-1:0]     err_count,
    output logic                 uncorrectable
);

    rscf_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  roots;
    logic [CNT_W-1:0]  deg_q;
    logic              bypass_q;
    logic              load_en;
    logic              push_en;
    logic              pop_en;
    logic              rx_wr;
    logic              is_root;
    logic [7:0]        err_val;
    logic [7:0]        lifo_top;
    logic [CNT_W-1:0]  lifo_level;
    logic [7:0]        rx_rd;
    logic [CNT_W-1:0]  rx_count;

    // Locator degree: the highest index with a nonzero coefficient.
    function automatic logic [CNT_W-1:0] lam_degree(input logic [(T+1)*8-1:0] v);
        logic [CNT_W-1:0] d;
        d = '0;
        for (int i = 0; i <= T; i++) if (v[i*8 +: 8] != 8'h00) d = CNT_W'(i);
        return d;
    endfunction

    // Control strobes for the submodules.
    always_comb begin
        load_en = (state == ST_IDLE) && start;
        push_en = (state == ST_SCAN);
        pop_en  = (state == ST_EMIT);
        rx_wr   = rx_valid && ((state == ST_SCAN) || (state == ST_HOLD)) && (rx_count < CNT_W'(N));
    end

    rscf_search #(.T(T)) u_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_en),
        .step        (push_en),
        .lambda_flat (lambda_coef),
        .omega_flat  (omega_coef),
        .is_root     (is_root),
        .err_val     (err_val)
    );

    rscf_lifo #(.DEPTH(N), .W(8)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_en),
        .pop   (pop_en),
        .din   (err_val),
        .dout  (lifo_top),
        .level (lifo_level)
    );

    rscf_rxbuf #(.DEPTH(N), .W(8)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load_en),
        .wr_en   (rx_wr),
        .wr_data (rx_sym),
        .rd_idx  (idx),
        .rd_data (rx_rd),
        .count   (rx_count)
    );

    // Sequencing: capture on start, count roots, latch status, walk the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            idx           <= '0;
            roots         <= '0;
            deg_q         <= '0;
            bypass_q      <= 1'b0;
            err_count     <= '0;
            uncorrectable <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SCAN;
                        idx      <= '0;
                        roots    <= '0;
                        bypass_q <= bypass;
                        deg_q    <= lam_degree(lambda_coef);
                    end
                end
                ST_SCAN: begin
                    roots <= roots + CNT_W'(is_root);
                    if (idx == IDX_W'(N - 1)) begin
                        idx   <= '0;
                        state <= ST_HOLD;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (rx_count == CNT_W'(N)) begin
                        state         <= ST_EMIT;
                        err_count     <= bypass_q ? '0 : roots;
                        uncorrectable <= !bypass_q && (roots != deg_q);
                    end
                end
                default: begin
                    if (idx == IDX_W'(N - 1)) begin
                        idx   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    // Output register: corrected or passed-through symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= pop_en;
            out_sym   <= (bypass_q || uncorrectable) ? rx_rd : (rx_rd ^ lifo_top);
        end
    end

endmodule

// File: rtl/rs_chien_corrector_chk.sv
// Module rs_chien_corrector_chk
// Property checker bound to rs_chien_corrector. It watches stack
// occupancy, output stream length and status stability.
module rs_chien_corrector_chk #(
    parameter int N = 219,
    localparam int CNT_W = $clog2(N + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             uncorrectable,
    input logic [CNT_W-1:0] err_count,
    input logic             bypass_q,
    input logic             push_en,
    input logic             pop_en,
    input logic [CNT_W-1:0] lifo_level
);

    logic [CNT_W-1:0] run_len;

    // Length of the current out_valid run.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_len <= '0;
        else if (out_valid) run_len <= run_len + CNT_W'(1);
        else                run_len <= '0;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (lifo_level < CNT_W'(N)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (lifo_level != '0));

    assert_stream_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_len < CNT_W'(N)));

    assert_first_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (lifo_level == CNT_W'(N - 1)));

    assert_bypass_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bypass_q) |-> (err_count == '0 && !uncorrectable));

    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> ($stable(err_count) && $stable(uncorrectable)));

endmodule

bind rs_chien_corrector rs_chien_corrector_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_valid     (out_valid),
    .uncorrectable (uncorrectable),
    .err_count     (err_count),
    .bypass_q      (bypass_q),
    .push_en       (push_en),
    .pop_en        (pop_en),
    .lifo_level    (lifo_level)
);

// File: tb/rs_chien_corrector_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each word and queues the results;
// the monitor compares the queued results with out_valid symbols as they leave.
module rs_chien_corrector_test;

    localparam int N = 219;
    localparam int T = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             bypass = 1'b0;
    logic [(T+1)*8-1:0] lambda_coef = '0;
    logic [T*8-1:0]   omega_coef = '0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_sym = '0;
    logic             out_valid;
    logic [7:0]       out_sym;
    logic [7:0]       err_count;
    logic             uncorrectable;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] lam_b [0:T];
    logic [7:0] om_b  [0:T-1];
    logic [7:0] rxw   [0:N-1];
    int         pos_list [0:15];
    int         npos;

    int  exp_sym_q[$];
    int  exp_cnt_q[$];
    int  exp_flag_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    rs_chien_corrector #(.N(N), .T(T)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
        .lambda_coef(lambda_coef), .omega_coef(omega_coef),
        .rx_valid(rx_valid), .rx_sym(rx_sym),
        .out_valid(out_valid), .out_sym(out_sym),
        .err_count(err_count), .uncorrectable(uncorrectable)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Field multiply: carry-less product, then reduce by 0x11D.
    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
        for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11D << (k - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] fpow(input int e);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < e; i++) r = fmul(r, 8'h02);
        return r;
    endfunction

    // Inverse by exhaustive search.
    function automatic logic [7:0] finv(input logic [7:0] x);
        for (int c = 1; c < 256; c++) if (fmul(x, 8'(c)) == 8'h01) return 8'(c);
        return 8'h00;
    endfunction

    function automatic logic [7:0] eval_lam(input logic [7:0] x);
        logic [7:0] acc;
        acc = '0;
        for (int i = T; i >= 0; i--) acc = fmul(acc, x) ^ lam_b[i];
        return acc;
    endfunction

    function automatic logic [7:0] eval_om(input logic [7:0] x);
        logic [7:0] acc;
        acc = '0;
        for (int i = T - 1; i >= 0; i--) acc = fmul(acc, x) ^ om_b[i];
        return acc;
    endfunction

    function automatic logic [7:0] eval_deriv(input logic [7:0] x);
        logic [7:0] acc;
        acc = '0;
        for (int i = 1; i <= T; i += 2) acc = acc ^ fmul(lam_b[i], fpow(0) == 8'h01 ? pow_x(x, i - 1) : 8'h00);
        return acc;
    endfunction

    function automatic logic [7:0] pow_x(input logic [7:0] x, input int e);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < e; i++) r = fmul(r, x);
        return r;
    endfunction

    // Locator from the listed error degrees: product of (1 + alpha^p x).
    task automatic build_lambda();
        for (int i = 0; i <= T; i++) lam_b[i] = (i == 0) ? 8'h01 : 8'h00;
        for (int k = 0; k < npos; k++) begin
            logic [7:0] xl;
            xl = fpow(pos_list[k] % 255);
            for (int i = T; i >= 1; i--) lam_b[i] = lam_b[i] ^ fmul(xl, lam_b[i-1]);
        end
    endtask

    task automatic set_omega(input int seed);
        for (int i = 0; i < T; i++) om_b[i] = 8'((seed * (i + 3) + 17 * i + 1) % 256);
    endtask

    // Predict the word, queue the results, then drive start and the received symbols.
    task automatic launch(input bit byp, input int gap, input bit poke, input string req);
        int roots;
        int deg;
        bit bad;
        logic [7:0] ev [0:N-1];
        for (int j = 0; j < N; j++) rxw[j] = 8'($urandom_range(0, 255));
        roots = 0;
        for (int j = 0; j < N; j++) begin
            logic [7:0] x;
            x = fpow((255 - (N - 1 - j)) % 255);
            ev[j] = 8'h00;
            if (eval_lam(x) == 8'h00) begin
                roots++;
                ev[j] = fmul(eval_om(x), finv(eval_deriv(x)));
            end
        end
        deg = 0;
        for (int i = 0; i <= T; i++) if (lam_b[i] != 8'h00) deg = i;
        bad = !byp && (roots != deg);
        for (int j = 0; j < N; j++)
            exp_sym_q.push_back((byp || bad) ? int'(rxw[j]) : int'(rxw[j] ^ ev[j]));
        exp_cnt_q.push_back(byp ? 0 : roots);
        exp_flag_q.push_back(int'(bad));
        req_q.push_back(req);

        @(negedge clk);
        for (int i = 0; i <= T; i++) lambda_coef[i*8 +: 8] = lam_b[i];
        for (int i = 0; i < T; i++)  omega_coef[i*8 +: 8]  = om_b[i];
        bypass = byp;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (gap > 0 && (j % gap) == gap - 1) begin
                rx_valid = 1'b0;
                repeat (3) @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_sym   = rxw[j];
            @(negedge clk);
        end
        rx_valid = 1'b0;
        if (poke) begin
            while (!out_valid) @(negedge clk);
            repeat (5) @(negedge clk);
            lambda_coef = '1;
            bypass      = 1'b1;
            start       = 1'b1;   // R9: must be ignored mid-stream
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_sym_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compare each output symbol and the status at the start of each word.
    bit prev_valid = 1'b0;
    string cur_req = "R2";
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_sym_q.size() == 0) begin
                check(1'b0, "R9 unexpected output", int'(out_sym), -1);
            end else begin
                if (!prev_valid) begin
                    cur_req = req_q.pop_front();
                    check(int'(err_count) == exp_cnt_q[0], {cur_req, " R6 err_count"}, int'(err_count), exp_cnt_q[0]);
                    check(int'(uncorrectable) == exp_flag_q[0], {cur_req, " R7 uncorrectable"}, int'(uncorrectable), exp_flag_q[0]);
                    void'(exp_cnt_q.pop_front());
                    void'(exp_flag_q.pop_front());
                end
                check(int'(out_sym) == exp_sym_q[0], {cur_req, " symbol"}, int'(out_sym), exp_sym_q[0]);
                void'(exp_sym_q.pop_front());
            end
        end
        prev_valid = rst_n && out_valid;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(err_count == 8'd0, "R1 err_count", int'(err_count), 0);
        check(uncorrectable == 1'b0, "R1 uncorrectable", int'(uncorrectable), 0);

        // R5/R2: no errors, locator = 1
        npos = 0; build_lambda(); set_omega(0);
        launch(1'b0, 0, 1'b0, "R5 R2 clean word");

        // R3/R4: a single error
        npos = 1; pos_list[0] = 5; build_lambda(); set_omega(11);
        launch(1'b0, 0, 1'b0, "R3 R4 single error");

        // R3/R4: nine errors, including both end positions
        npos = 9;
        pos_list[0] = 0;   pos_list[1] = 218; pos_list[2] = 1;
        pos_list[3] = 50;  pos_list[4] = 100; pos_list[5] = 101;
        pos_list[6] = 150; pos_list[7] = 200; pos_list[8] = 217;
        build_lambda(); set_omega(29);
        launch(1'b0, 0, 1'b0, "R3 R4 nine errors");

        // R7: one root lies beyond the shortened length
        npos = 2; pos_list[0] = 10; pos_list[1] = 230; build_lambda(); set_omega(7);
        launch(1'b0, 0, 1'b0, "R7 root outside");

        // R8: bypass with a locator that has roots
        npos = 3; pos_list[0] = 3; pos_list[1] = 77; pos_list[2] = 140; build_lambda(); set_omega(5);
        launch(1'b1, 0, 1'b0, "R8 bypass");

        // R10: received symbols with gaps
        npos = 4; pos_list[0] = 2; pos_list[1] = 60; pos_list[2] = 61; pos_list[3] = 210;
        build_lambda(); set_omega(41);
        launch(1'b0, 7, 1'b0, "R10 gapped input");

        // R9: a start pulse during output is ignored
        npos = 2; pos_list[0] = 20; pos_list[1] = 190; build_lambda(); set_omega(3);
        launch(1'b0, 0, 1'b1, "R9 start while busy");
        repeat (300) @(negedge clk);
        check(out_valid == 1'b0, "R9 no extra stream", int'(out_valid), 0);

        // The block still runs normally after the ignored start.
        npos = 1; pos_list[0] = 218; build_lambda(); set_omega(99);
        launch(1'b0, 0, 1'b0, "R3 R4 top position");

        done = 1'b1;
        finish_run();
    end

endmodule